// File: doc/BRIEF.md
# Integer Execution Unit with Barrel Shifter

This block is the integer execution stage of a three-operand register-register processor. Each cycle it can accept two 32-bit operands, a 16-bit immediate, a 5-bit shift amount and a 4-bit operation code. One cycle later it returns a registered 32-bit result, a flag that is set when that result is zero, and a valid strobe.

The operation set covers the following:
- wrap-around add and subtract
- the bitwise functions and, or and nor
- signed and unsigned compare-to-flag
- shifts by a constant amount: left logical, right logical and right arithmetic
- loading the immediate into the upper half

When `useImm` is set, the extended immediate replaces operand B. The operation class sets the extension rule: arithmetic and compare operations sign-extend, and bitwise operations zero-extend. The zero flag lets a subtract feed an equality branch decision.

Top module: `alu_core`

## Requirements
- R1: Op code 0 (add) gives A+B and op code 1 (subtract) gives A-B, both modulo 2^32, with no overflow indication.
- R2: Op codes 2 (and), 3 (or) and 4 (nor) act bitwise. Nor gives ~(A|B).
- R3: Op code 5 (signed set-less-than) and op code 6 (unsigned set-less-than) give 1 when A<B and 0 otherwise, so bits 31:1 are always 0. The signed form compares in two's complement. For A=0xFFFFFFFA and B=0x0000FFFA, op 5 gives 1 and op 6 gives 0.
- R4: Op codes 7 (left logical), 8 (right logical) and 9 (right arithmetic) shift operand A by `shamt` (0 to 31). The logical shifts fill vacated bits with 0, and the arithmetic shift fills them with A[31]. Operand B and `useImm` have no effect on a shift.
- R5: With `useImm`=1, operand B is replaced by the immediate. Ops 0, 1, 5 and 6 sign-extend it, and ops 2, 3 and 4 zero-extend it. For example, or with immediate 0xFFFF on 0x12345678 gives 0x1234FFFF.
- R6: Op code 10 gives {imm, 16'h0000}, whatever the values of A, B and `useImm`.
- R7: `zeroFlag` is 1 exactly when `result` is 0.
- R8: `outValid` is `inValid` delayed by one clock. `result` and `zeroFlag` are those of the operation accepted on that edge.
- R9: While `inValid` is 0, `result` and `zeroFlag` hold their values.
- R10: During reset, `outValid`=0, `result`=0 and `zeroFlag`=1.
- R11: Op codes 11 to 15 are reserved and give result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 4 | Operation code |
| opA | input | 32 | Operand A, also the shift source |
| opB | input | 32 | Operand B |
| imm | input | 16 | Immediate field |
| useImm | input | 1 | Replace B with the extended immediate |
| shamt | input | 5 | Shift amount |
| outValid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| zeroFlag | output | 1 | Result equals zero |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency
- the agreement between the zero flag and the result
- that the outputs hold while idle
- that compare results have only bit 0 free
- that the low half of an upper-immediate result is cleared

Whether a value is arithmetically right can only be shown by the bench's scenarios, which compare against a reference model. These cover the following:
- sums that wrap
- signed and unsigned compares that disagree
- shift fill at amounts 0 and 31
- the two extension rules
- operands ignored by the upper-immediate op
- reserved codes

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9,
    OP_LUI  = 4'd10
  } aluOp_e;

  typedef enum logic [2:0] {
    RES_SUM   = 3'd0,
    RES_AND   = 3'd1,
    RES_OR    = 3'd2,
    RES_NOR   = 3'd3,
    RES_CMP   = 3'd4,
    RES_SHIFT = 3'd5,
    RES_UPPER = 3'd6,
    RES_NONE  = 3'd7
  } resSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    bImm;
    logic    extSign;
    logic    subtract;
    logic    cmpUnsigned;
    logic    shLeft;
    logic    shArith;
    resSel_e resSel;
  } aluCtl_t;
endpackage

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import alu_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [3:0]    opSel,
  input  logic          useImm,
  output aluCtl_t       ctl,
  output logic          outValid
);
  always_comb begin
    ctl = '{bImm: 1'b0, extSign: 1'b0, subtract: 1'b0, cmpUnsigned: 1'b0,
            shLeft: 1'b0, shArith: 1'b0, resSel: RES_NONE};
    case (opSel)
      OP_ADD:  begin ctl.resSel = RES_SUM; ctl.bImm = useImm; ctl.extSign = 1'b1; end
      OP_SUB:  begin ctl.resSel = RES_SUM; ctl.bImm = useImm; ctl.extSign = 1'b1;
                     ctl.subtract = 1'b1; end
      OP_AND:  begin ctl.resSel = RES_AND; ctl.bImm = useImm; end
      OP_OR:   begin ctl.resSel = RES_OR;  ctl.bImm = useImm; end
      OP_NOR:  begin ctl.resSel = RES_NOR; ctl.bImm = useImm; end
      OP_SLT:  begin ctl.resSel = RES_CMP; ctl.bImm = useImm; ctl.extSign = 1'b1; end
      OP_SLTU: begin ctl.resSel = RES_CMP; ctl.bImm = useImm; ctl.extSign = 1'b1;
                     ctl.cmpUnsigned = 1'b1; end
      OP_SLL:  begin ctl.resSel = RES_SHIFT; ctl.shLeft = 1'b1; end
      OP_SRL:  begin ctl.resSel = RES_SHIFT; end
      OP_SRA:  begin ctl.resSel = RES_SHIFT; ctl.shArith = 1'b1; end
      OP_LUI:  begin ctl.resSel = RES_UPPER; end
      default: ctl.resSel = RES_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R8: valid output trails valid input by exactly one edge
  p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/alu_dpath.sv
`timescale 1ns/1ps
module alu_dpath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMMW  = 16,
  localparam int SHW  = $clog2(WIDTH),
  localparam int LOWW = WIDTH - IMMW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capture,
  input  aluCtl_t          ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [IMMW-1:0]  imm,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag
);
  logic [WIDTH-1:0] immExt, bOp, bAdd, sumVal, cmpVal, shiftVal, upperVal, nextVal;
  logic [WIDTH-1:0] shIn, shOut;
  logic [WIDTH-1:0] stage [SHW+1];
  logic             fillBit, lessSigned, lessUnsigned;

  assign immExt = ctl.extSign ? {{LOWW{imm[IMMW-1]}}, imm} : {{LOWW{1'b0}}, imm};
  assign bOp    = ctl.bImm ? immExt : opB;

  // adder, wraps modulo 2^WIDTH
  assign bAdd   = ctl.subtract ? ~bOp : bOp;
  assign sumVal = opA + bAdd + {{(WIDTH-1){1'b0}}, ctl.subtract};

  assign lessSigned   = $signed(opA) < $signed(bOp);
  assign lessUnsigned = opA < bOp;
  assign cmpVal = {{(WIDTH-1){1'b0}}, ctl.cmpUnsigned ? lessUnsigned : lessSigned};

  // single right barrel shifter; left shifts reverse bits around it
  assign fillBit = ctl.shArith & opA[WIDTH-1];
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign shIn[i]     = ctl.shLeft ? opA[WIDTH-1-i] : opA[i];
    assign shiftVal[i] = ctl.shLeft ? shOut[WIDTH-1-i] : shOut[i];
  end
  assign stage[0] = shIn;
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = shamt[k] ? {{STEP{fillBit}}, stage[k][WIDTH-1:STEP]} : stage[k];
  end
  assign shOut = stage[SHW];

  assign upperVal = {imm, {LOWW{1'b0}}};

  always_comb begin
    case (ctl.resSel)
      RES_SUM:   nextVal = sumVal;
      RES_AND:   nextVal = opA & bOp;
      RES_OR:    nextVal = opA | bOp;
      RES_NOR:   nextVal = ~(opA | bOp);
      RES_CMP:   nextVal = cmpVal;
      RES_SHIFT: nextVal = shiftVal;
      RES_UPPER: nextVal = upperVal;
      default:   nextVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      zeroFlag <= 1'b1;
    end else if (capture) begin
      result   <= nextVal;
      zeroFlag <= (nextVal == '0);
    end
  end

  // R7: flag agrees with the registered result
  p_zero_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    zeroFlag == (result == '0));
  // R9: idle cycles leave outputs untouched
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> ($stable(result) && $stable(zeroFlag)));
  // R3: a compare only ever drives bit 0
  p_cmp_bool_r3: assert property (@(posedge clk) disable iff (!rstN)
    (capture && ctl.resSel == RES_CMP) |=> (result[WIDTH-1:1] == '0));
  // R6: upper-immediate clears the low part
  p_upper_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (capture && ctl.resSel == RES_UPPER) |=> (result[LOWW-1:0] == '0));
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMMW  = 16,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [IMMW-1:0]  imm,
  input  logic             useImm,
  input  logic [SHW-1:0]   shamt,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag
);
  aluCtl_t ctl;

  alu_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .useImm(useImm), .ctl(ctl), .outValid(outValid)
  );

  alu_dpath #(.WIDTH(WIDTH), .IMMW(IMMW)) i_dpath (
    .clk(clk), .rstN(rstN), .capture(inValid), .ctl(ctl),
    .opA(opA), .opB(opB), .imm(imm), .shamt(shamt),
    .result(result), .zeroFlag(zeroFlag)
  );
endmodule

// File: tb/test_alu_core.sv
`timescale 1ns/1ps
module test_alu_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [15:0] imm = '0;
  logic        useImm = 1'b0;
  logic [4:0]  shamt = '0;
  logic        outValid, zeroFlag;
  logic [31:0] result;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  alu_core i_alu_core (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .opA(opA),
    .opB(opB), .imm(imm), .useImm(useImm), .shamt(shamt),
    .outValid(outValid), .result(result), .zeroFlag(zeroFlag)
  );

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic ui, input logic [4:0] sh);
    logic [31:0] bs, bz;
    bs = ui ? {{16{im[15]}}, im} : b;
    bz = ui ? {16'h0, im} : b;
    case (op)
      4'd0:  return a + bs;
      4'd1:  return a - bs;
      4'd2:  return a & bz;
      4'd3:  return a | bz;
      4'd4:  return ~(a | bz);
      4'd5:  return ($signed(a) < $signed(bs)) ? 32'd1 : 32'd0;
      4'd6:  return (a < bs) ? 32'd1 : 32'd0;
      4'd7:  return a << sh;
      4'd8:  return a >> sh;
      4'd9:  return 32'($signed(a) >>> sh);
      4'd10: return {im, 16'h0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:       return "R1";
      4'd2, 4'd3, 4'd4: return "R2";
      4'd5, 4'd6:       return "R3";
      4'd7, 4'd8, 4'd9: return "R4";
      4'd10:            return "R6";
      default:          return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one operation, then sample one cycle later away from the edge
  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] im, input logic ui, input logic [4:0] sh,
                     input string tag);
    logic [31:0] exp;
    exp = model(op, a, b, im, ui, sh);
    @(negedge clk);
    opSel = op; opA = a; opB = b; imm = im; useImm = ui; shamt = sh; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, "R8", {31'b0, outValid}, 32'd1);
    check(result === exp, tag, result, exp);
    check(zeroFlag === (exp == 0), "R7", {31'b0, zeroFlag}, {31'b0, exp == 0});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    // R10 reset state
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R10", {31'b0, outValid}, 32'd0);
    check(result === 32'd0, "R10", result, 32'd0);
    check(zeroFlag === 1'b1, "R10", {31'b0, zeroFlag}, 32'd1);
    rstN = 1'b1;

    // R1 wrap-around
    run(4'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, "R1");
    run(4'd1, 32'd0, 32'd1, 16'h0, 1'b0, 5'd0, "R1");
    run(4'd1, 32'h1234_5678, 32'h1234_5678, 16'h0, 1'b0, 5'd0, "R1");
    // R2 bitwise
    run(4'd4, 32'h0F0F_0000, 32'h0000_00FF, 16'h0, 1'b0, 5'd0, "R2");
    run(4'd2, 32'hB6A4_3D9A, 32'h0000_0FFF, 16'h0, 1'b0, 5'd0, "R2");
    // R3 signed vs unsigned disagree
    run(4'd5, 32'hFFFF_FFFA, 32'h0000_FFFA, 16'h0, 1'b0, 5'd0, "R3");
    run(4'd6, 32'hFFFF_FFFA, 32'h0000_FFFA, 16'h0, 1'b0, 5'd0, "R3");
    run(4'd5, 32'd7, 32'd7, 16'h0, 1'b0, 5'd0, "R3");
    // R4 shift fill and range ends, B/useImm ignored
    run(4'd9, 32'h8000_0000, 32'hFFFF_FFFF, 16'hFFFF, 1'b1, 5'd31, "R4");
    run(4'd8, 32'h8000_0000, 32'h1, 16'h0, 1'b0, 5'd31, "R4");
    run(4'd7, 32'h1234_5678, 32'h0, 16'h0, 1'b0, 5'd8, "R4");
    run(4'd9, 32'h1234_5678, 32'h0, 16'h0, 1'b0, 5'd0, "R4");
    run(4'd9, 32'h9234_5678, 32'h0, 16'h0, 1'b0, 5'd8, "R4");
    // R5 extension rules
    run(4'd3, 32'h1234_5678, 32'hDEAD_BEEF, 16'hFFFF, 1'b1, 5'd0, "R5");
    run(4'd0, 32'd100, 32'h0, 16'hFFCE, 1'b1, 5'd0, "R5");
    run(4'd2, 32'hFFFF_FFFF, 32'h0, 16'h8001, 1'b1, 5'd0, "R5");
    run(4'd6, 32'h7FFF_FFFF, 32'h0, 16'h8000, 1'b1, 5'd0, "R5");
    // R6 upper immediate ignores A, B, useImm
    run(4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 1'b0, 5'd3, "R6");
    run(4'd10, 32'h1, 32'h2, 16'h0000, 1'b1, 5'd0, "R6");
    // R11 reserved codes
    for (int c = 11; c < 16; c++) run(4'(c), 32'hFFFF_FFFF, 32'h1, 16'h5, 1'b0, 5'd1, "R11");

    // R9 hold while idle with changed inputs
    run(4'd0, 32'd5, 32'd6, 16'h0, 1'b0, 5'd0, "R1");
    held = result;
    opSel = 4'd1; opA = 32'd6; opB = 32'd6;
    @(negedge clk);
    check(outValid === 1'b0, "R8", {31'b0, outValid}, 32'd0);
    check(result === held, "R9", result, held);
    check(zeroFlag === 1'b0, "R9", {31'b0, zeroFlag}, 32'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 11));
      run(op, $urandom(), (n % 7 == 0) ? 32'h0 : $urandom(), 16'($urandom()),
          1'($urandom()), 5'($urandom()), tagOf(op));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule